// File: doc/BRIEF.md
# Pad Configuration Chain Streamer

This block copies the staged configuration words of 38 pads out to the pad-side storage over two serial chains that run side by side. The lower chain reaches pads 18 down to 0 and the upper chain reaches pads 19 up to 37. Each pad owns a 13-bit word. Every pad-side stage shifts on the rising edge of a shared chain clock, and one shared load strobe makes all stages take the shifted value at once. A one-cycle start pulse begins a transfer. The `busy` output shows that a transfer is running and reads back in the position of the start bit. A diagnostic bypass (`bb_en`) lets software drive the chain clock, both data lines, the load strobe and the active-low chain reset directly.

The sequencer has four states. `ST_IDLE` waits for a start. `ST_LOW` drives the current bit with the chain clock low. `ST_HIGH` raises the chain clock with the data held. `ST_LOAD` pulses the load strobe. The transitions are as follows:

- `ST_IDLE` goes to `ST_LOW` on an accepted start.
- `ST_LOW` always goes to `ST_HIGH`.
- `ST_HIGH` goes back to `ST_LOW` while bits remain, or to `ST_LOAD` after the final bit.
- `ST_LOAD` always returns to `ST_IDLE`.

Top module: `gpio_cfg_serializer`

## Requirements
- R1: Pad p's word occupies `cfg_words[13p+12:13p]`. The lower chain sends pad 18 first and pad 0 last, each word most significant bit first. Its first bit is bit 12 of pad 18 and its last is bit 0 of pad 0.
- R2: In the same chain clocks as the lower chain, the upper chain sends pad 19 first and pad 37 last, each word most significant bit first.
- R3: A transfer gives exactly 247 chain clock pulses at half the system clock rate, each one cycle low and then one cycle high. Data changes only in the low cycle and holds through the high cycle.
- R4: In the cycle after the final high phase, `chain_load` is 1 for exactly one cycle, once per transfer.
- R5: `busy` goes to 1 in the cycle after an accepted start and goes to 0 in the cycle after the load strobe. It is 1 for 495 cycles in all.
- R6: A start pulse while `busy` is 1 is ignored. The running transfer keeps its length and bit order, and no second transfer follows.
- R7: A start pulse while `bb_en` is 1 is ignored. `busy` stays 0.
- R8: While `bb_en` is 1, `chain_clk`, `chain_data_r`, `chain_data_l` and `chain_load` equal `bb_clk`, `bb_data_r`, `bb_data_l` and `bb_load` in the same cycle.
- R9: `chain_rstn` equals `bb_rstn` while `bb_en` is 1. A 0 returns all pads to their defaults. `chain_rstn` is 1 while `bb_en` is 0.
- R10: After reset, `busy`, `chain_clk`, `chain_load`, `chain_data_r` and `chain_data_l` are 0 and `chain_rstn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_words | input | 494 | Staged words, pad p at bits [13p+12:13p] |
| start_wr | input | 1 | One-cycle pulse, write of 1 to the start bit |
| bb_en | input | 1 | Diagnostic bypass enable |
| bb_clk | input | 1 | Bypass chain clock |
| bb_data_r | input | 1 | Bypass data for lower chain |
| bb_data_l | input | 1 | Bypass data for upper chain |
| bb_load | input | 1 | Bypass load strobe |
| bb_rstn | input | 1 | Bypass chain reset, active low |
| busy | output | 1 | Transfer in progress |
| chain_clk | output | 1 | Chain shift clock |
| chain_data_r | output | 1 | Lower chain serial data |
| chain_data_l | output | 1 | Upper chain serial data |
| chain_load | output | 1 | Chain load strobe |
| chain_rstn | output | 1 | Chain reset, active low |

## Verification
The checks assume that `bb_en` does not change during an automatic transfer and that `cfg_words` stays steady while `busy` is 1, because the chains read the staged words live. The stimulus changes the words and the bypass enable only while the block is idle. The only start pulses it raises during a transfer are those that test R6, and its start pulses last one cycle each.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_LOAD = 2'd3
    } gsc_state_e;
endpackage

// File: rtl/gsc_cursor.sv
// Walks pad index upward and bit index downward across one chain.
module gsc_cursor #(
    parameter int PADS = 19,
    parameter int BITS = 13,
    localparam int PW = $clog2(PADS),
    localparam int BW = $clog2(BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [PW-1:0] pad_idx,
    output logic [BW-1:0] bit_idx,
    output logic          last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pad_idx <= '0;
            bit_idx <= BW'(BITS - 1);
        end else if (clear) begin
            pad_idx <= '0;
            bit_idx <= BW'(BITS - 1);
        end else if (step) begin
            if (bit_idx == '0) begin
                bit_idx <= BW'(BITS - 1);
                pad_idx <= pad_idx + PW'(1);
            end else begin
                bit_idx <= bit_idx - BW'(1);
            end
        end
    end

    assign last = (pad_idx == PW'(PADS - 1)) && (bit_idx == '0);
endmodule

// File: rtl/gsc_pick.sv
// Selects the serial bit of one chain; DESCEND walks pads from the top down.
module gsc_pick #(
    parameter int PADS    = 19,
    parameter int BITS    = 13,
    parameter bit DESCEND = 1'b0,
    localparam int PW = $clog2(PADS),
    localparam int BW = $clog2(BITS),
    localparam int CW = PADS * BITS,
    localparam int SW = $clog2(CW)
) (
    input  logic [CW-1:0] words,
    input  logic [PW-1:0] pad_idx,
    input  logic [BW-1:0] bit_idx,
    output logic          sbit
);
    logic [SW-1:0] sel;

    always_comb begin
        int pad;
        if (DESCEND) pad = PADS - 1 - int'(pad_idx);
        else         pad = int'(pad_idx);
        sel  = SW'(pad * BITS + int'(bit_idx));
        sbit = words[sel];
    end
endmodule

// File: rtl/gpio_cfg_serializer.sv
module gpio_cfg_serializer
    import gsc_pkg::*;
#(
    parameter int PADS_PER_CHAIN = 19,
    parameter int CFG_BITS       = 13,
    localparam int CHAIN_W = PADS_PER_CHAIN * CFG_BITS,
    localparam int ALL_W   = 2 * CHAIN_W,
    localparam int PW      = $clog2(PADS_PER_CHAIN),
    localparam int BW      = $clog2(CFG_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ALL_W-1:0] cfg_words,
    input  logic             start_wr,
    input  logic             bb_en,
    input  logic             bb_clk,
    input  logic             bb_data_r,
    input  logic             bb_data_l,
    input  logic             bb_load,
    input  logic             bb_rstn,
    output logic             busy,
    output logic             chain_clk,
    output logic             chain_data_r,
    output logic             chain_data_l,
    output logic             chain_load,
    output logic             chain_rstn
);
    gsc_state_e state, state_nx;

    logic [PW-1:0] pad_idx;
    logic [BW-1:0] bit_idx;
    logic          last_bit;
    logic          cur_clear, cur_step;
    logic [1:0]    pick_bit;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start_wr && !bb_en) state_nx = ST_LOW;
            ST_LOW:  state_nx = ST_HIGH;
            ST_HIGH: state_nx = last_bit ? ST_LOAD : ST_LOW;
            ST_LOAD: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign cur_clear = (state == ST_IDLE);
    assign cur_step  = (state == ST_HIGH) && !last_bit;

    gsc_cursor #(.PADS(PADS_PER_CHAIN), .BITS(CFG_BITS)) u_cursor (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cur_clear),
        .step    (cur_step),
        .pad_idx (pad_idx),
        .bit_idx (bit_idx),
        .last    (last_bit)
    );

    // Chain 0 (lower pads) walks downward, chain 1 (upper pads) upward.
    for (genvar c = 0; c < 2; c++) begin : g_chain
        gsc_pick #(
            .PADS    (PADS_PER_CHAIN),
            .BITS    (CFG_BITS),
            .DESCEND (c == 0)
        ) u_pick (
            .words   (cfg_words[c*CHAIN_W +: CHAIN_W]),
            .pad_idx (pad_idx),
            .bit_idx (bit_idx),
            .sbit    (pick_bit[c])
        );
    end

    always_comb begin
        logic a_clk, a_load, a_drive;
        a_clk   = 1'b0;
        a_load  = 1'b0;
        a_drive = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_LOW:  a_drive = 1'b1;
            ST_HIGH: begin a_drive = 1'b1; a_clk = 1'b1; end
            ST_LOAD: a_load = 1'b1;
            default: ;
        endcase
        busy = (state != ST_IDLE);
        if (bb_en) begin
            chain_clk    = bb_clk;
            chain_data_r = bb_data_r;
            chain_data_l = bb_data_l;
            chain_load   = bb_load;
            chain_rstn   = bb_rstn;
        end else begin
            chain_clk    = a_clk;
            chain_data_r = a_drive & pick_bit[0];
            chain_data_l = a_drive & pick_bit[1];
            chain_load   = a_load;
            chain_rstn   = 1'b1;
        end
    end
endmodule

// File: rtl/gsc_checker.sv
module gsc_checker #(
    parameter int PADS = 19,
    parameter int BITS = 13,
    localparam int NB = PADS * BITS,
    localparam int CW = $clog2(NB + 1)
) (
    input logic clk,
    input logic rst_n,
    input logic start_wr,
    input logic bb_en,
    input logic bb_clk,
    input logic bb_load,
    input logic bb_rstn,
    input logic busy,
    input logic chain_clk,
    input logic chain_data_r,
    input logic chain_data_l,
    input logic chain_load,
    input logic chain_rstn
);
    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 hi_cnt <= '0;
        else if (!busy)                             hi_cnt <= '0;
        else if (!bb_en && chain_clk && hi_cnt < CW'(NB)) hi_cnt <= hi_cnt + CW'(1);
    end

    // R3
    stable_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bb_en && !$past(bb_en) && $rose(chain_clk)) |-> ($stable(chain_data_r) && $stable(chain_data_l)));
    // R3
    clk_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bb_en && chain_load) |-> (hi_cnt == CW'(NB)));
    // R4
    load_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bb_en && chain_load) |=> !busy);
    // R5
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_wr && !bb_en));
    // R8
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bb_en |-> (chain_clk == bb_clk && chain_load == bb_load));
    // R9
    chain_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bb_en |-> chain_rstn) and (bb_en |-> chain_rstn == bb_rstn));
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bb_en && !busy) |-> (!chain_clk && !chain_load && !chain_data_r && !chain_data_l));
endmodule

bind gpio_cfg_serializer gsc_checker #(.PADS(PADS_PER_CHAIN), .BITS(CFG_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_wr     (start_wr),
    .bb_en        (bb_en),
    .bb_clk       (bb_clk),
    .bb_load      (bb_load),
    .bb_rstn      (bb_rstn),
    .busy         (busy),
    .chain_clk    (chain_clk),
    .chain_data_r (chain_data_r),
    .chain_data_l (chain_data_l),
    .chain_load   (chain_load),
    .chain_rstn   (chain_rstn)
);

// File: tb/gpio_cfg_serializer_test.sv
`timescale 1ns/1ps
module gpio_cfg_serializer_test;
    localparam int NP   = 19;
    localparam int NBIT = 13;
    localparam int NCH  = NP * NBIT;
    localparam int NALL = 2 * NCH;
    localparam int XFER_CYC = 2 * NCH + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NALL-1:0] cfg_words = '0;
    logic start_wr = 0, bb_en = 0, bb_clk = 0, bb_data_r = 0, bb_data_l = 0, bb_load = 0, bb_rstn = 1;
    logic busy, chain_clk, chain_data_r, chain_data_l, chain_load, chain_rstn;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    gpio_cfg_serializer uut (
        .clk(clk), .rst_n(rst_n), .cfg_words(cfg_words), .start_wr(start_wr),
        .bb_en(bb_en), .bb_clk(bb_clk), .bb_data_r(bb_data_r), .bb_data_l(bb_data_l),
        .bb_load(bb_load), .bb_rstn(bb_rstn), .busy(busy), .chain_clk(chain_clk),
        .chain_data_r(chain_data_r), .chain_data_l(chain_data_l),
        .chain_load(chain_load), .chain_rstn(chain_rstn)
    );

    // Stimulus table: seed per vector and mid-transfer restart cycle (-1 = none).
    localparam logic [12:0] VEC_SEED [0:5] = '{13'h0000, 13'h1FFF, 13'h0AAA, 13'h1555, 13'h0F0F, 13'h1234};
    localparam int          VEC_POKE [0:5] = '{-1, -1, 7, -1, 300, 493};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [12:0] pad_word(input logic [12:0] seed, input int p);
        pad_word = 13'((int'(seed) + p * 2647) ^ (p << 4) ^ (p * 7));
    endfunction

    function automatic logic exp_bit(input logic [NALL-1:0] w, input int k, input bit upper);
        int pad;
        pad = upper ? (NP + k / NBIT) : (NP - 1 - k / NBIT);
        exp_bit = w[pad * NBIT + (NBIT - 1 - k % NBIT)];
    endfunction

    task automatic run_xfer(input int poke);
        int  hi_n = 0, busy_n = 0, load_n = 0, bad_r = 0, bad_l = 0, unstable = 0, load_at = -1;
        logic pr = 0, pl = 0;
        @(negedge clk); start_wr = 1;
        @(negedge clk); start_wr = 0;
        while (busy && busy_n < 2000) begin
            if (busy_n == poke) start_wr = 1;
            else                start_wr = 0;
            if (chain_clk) begin
                if (chain_data_r !== pr || chain_data_l !== pl) unstable++;
                if (hi_n < NCH) begin
                    if (chain_data_r !== exp_bit(cfg_words, hi_n, 1'b0)) bad_r++;
                    if (chain_data_l !== exp_bit(cfg_words, hi_n, 1'b1)) bad_l++;
                end
                hi_n++;
            end
            if (chain_load) begin load_n++; load_at = hi_n; end
            pr = chain_data_r;
            pl = chain_data_l;
            busy_n++;
            @(negedge clk);
        end
        start_wr = 0;
        chk("R1 lower chain bit errors", bad_r, 0);
        chk("R2 upper chain bit errors", bad_l, 0);
        chk("R3 chain clock pulses", hi_n, NCH);
        chk("R3 data stable in high phase", unstable, 0);
        chk("R4 load strobes", load_n, 1);
        chk("R4 load after final pulse", load_at, NCH);
        chk("R5 busy cycles", busy_n, XFER_CYC);
        if (poke >= 0) begin
            @(negedge clk);
            chk("R6 no second transfer after start during busy", busy, 0);
        end
    endtask

    initial begin
        #1_000_000;
        fails++; tests++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 busy", busy, 0);
        chk("R10 chain_clk", chain_clk, 0);
        chk("R10 chain_load", chain_load, 0);
        chk("R10 data", {chain_data_r, chain_data_l}, 0);
        chk("R10 chain_rstn", chain_rstn, 1);
        rst_n = 1;
        @(negedge clk);

        for (int v = 0; v < 6; v++) begin
            for (int p = 0; p < 2 * NP; p++)
                cfg_words[p * NBIT +: NBIT] = pad_word(VEC_SEED[v], p);
            run_xfer(VEC_POKE[v]);
        end

        // R1 R2 single hot bits at the chain ends
        cfg_words = '0;
        cfg_words[(NP - 1) * NBIT + NBIT - 1] = 1'b1;
        cfg_words[NP * NBIT + NBIT - 1] = 1'b1;
        cfg_words[0] = 1'b1;
        cfg_words[NALL - NBIT] = 1'b1;
        run_xfer(-1);

        // R8 R9 bypass passthrough
        bb_en = 1;
        for (int m = 0; m < 32; m++) begin
            {bb_clk, bb_data_r, bb_data_l, bb_load, bb_rstn} = 5'(m);
            #1;
            chk("R8 bypass outputs", {chain_clk, chain_data_r, chain_data_l, chain_load}, {bb_clk, bb_data_r, bb_data_l, bb_load});
            chk("R9 bypass chain reset", chain_rstn, bb_rstn);
            @(negedge clk);
        end
        // R7 start ignored in bypass mode
        {bb_clk, bb_data_r, bb_data_l, bb_load, bb_rstn} = 5'b00001;
        start_wr = 1;
        @(negedge clk); start_wr = 0;
        chk("R7 busy after start in bypass", busy, 0);
        @(negedge clk);
        chk("R7 busy stays low", busy, 0);
        // R9 reset-bar ignored outside bypass
        bb_rstn = 0;
        bb_en = 0;
        #1;
        chk("R9 chain_rstn outside bypass", chain_rstn, 1);
        chk("R7 no transfer pending", busy, 0);
        bb_rstn = 1;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule